// File: doc/BRIEF.md
# Byte/Word ALU with Status Flags

A purely combinational arithmetic and logic unit for a 16-bit register machine that can operate on a full word or on the low byte only. One opcode selects among sixteen operations: binary add and subtract (with and without incoming carry), compare, decimal add, four bitwise operations plus a bit test, three right shifts, a byte swap and a sign extension. The unit returns the result, a four-bit status vector and a write-enable per status bit. It also returns a result write-enable that the surrounding datapath uses to decide whether the destination is updated.

Opcode encoding on `op_i`: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 compare, 5 decimal add, 6 and, 7 bit test, 8 bit clear, 9 bit set, 10 xor, 11 rotate right through carry, 12 arithmetic shift right, 13 logical shift right, 14 byte swap, 15 sign extend. Status vector bit positions: bit 0 carry (C), bit 1 zero (Z), bit 2 negative (N), bit 3 overflow (V). Two-operand operations compute `dst op src`; one-operand operations (11 to 15) act on `dst_i` alone.

Top module: `bw_alu`

## Requirements
- R1: Add produces dst+src and add with carry produces dst+src+carry_i; C is the bit carried out above the operand width and V is set when two operands of equal sign give a result of the other sign.
- R2: Subtract produces dst+~src+1 and subtract with carry produces dst+~src+carry_i; C is the carry out of that sum (1 means no borrow) and V is set when the signed difference does not fit the operand width.
- R3: Compare (4) and bit test (7) update the status bits but drive `result_we_o` low; every other opcode drives it high.
- R4: Decimal add treats each 4-bit digit as a decimal digit, adds both operands and carry_i, returns the sum modulo 100 (byte) or 10000 (word) in BCD, sets C when the sum exceeds 99 (byte) or 9999 (word), and leaves V unwritten (flag write-enables 4'b0111).
- R5: And and bit test return dst&src with C = result nonzero and V = 0.
- R6: Xor returns dst^src with C = result nonzero and V = 1 exactly when both operands have their sign bit set.
- R7: Bit clear returns dst&~src, bit set returns dst|src, byte swap exchanges the two bytes; all three drive `flag_we_o` to 4'b0000; every other opcode except decimal add drives it to 4'b1111.
- R8: Rotate right through carry shifts carry_i into the top bit of the selected size and bit 0 out into C; V = 0.
- R9: Arithmetic shift right keeps the sign bit of the selected size, logical shift right fills it with zero; both move bit 0 into C and clear V.
- R10: Byte swap and sign extend always work on the full word whatever `byte_i` says; sign extend copies bit 7 into bits 15:8 and sets C = result nonzero, V = 0.
- R11: With `byte_i` high (all opcodes but 14 and 15) operand bits 15:8 are ignored, result bits 15:8 are zero, N is result bit 7 and Z tests bits 7:0.
- R12: In word size N is result bit 15 and Z is set when all 16 result bits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand, sole operand of one-operand opcodes |
| op_i | input | 4 | Operation select (encoding above) |
| byte_i | input | 1 | 1 selects byte size, 0 word size |
| carry_i | input | 1 | Incoming carry status bit |
| result_o | output | 16 | Operation result |
| flags_o | output | 4 | New status bits {V,N,Z,C} |
| flag_we_o | output | 4 | Per-bit status write-enable, same bit order |
| result_we_o | output | 1 | Destination write-enable |

## Verification
Every output is a combinational function of the present inputs, so each result is due in the same cycle as its stimulus with zero register stages. The bench applies a vector just after a rising clock edge and samples all outputs at the following falling edge, half a period later, once everything has settled. Status bits are compared only where the matching write-enable is expected high, since unwritten bits carry no meaning.

// File: rtl/bw_alu_pkg.sv
package bw_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_CMP  = 4'd4,
    OP_DADD = 4'd5,
    OP_AND  = 4'd6,
    OP_BIT  = 4'd7,
    OP_BIC  = 4'd8,
    OP_BIS  = 4'd9,
    OP_XOR  = 4'd10,
    OP_RRC  = 4'd11,
    OP_RRA  = 4'd12,
    OP_RRL  = 4'd13,
    OP_SWPB = 4'd14,
    OP_SXT  = 4'd15
  } alu_op_e;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_W = 4;

endpackage

// File: rtl/bw_alu_arith.sv
module bw_alu_arith
  import bw_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  alu_op_e           op_i,
  input  logic              byte_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              ovf_o
);
  localparam int HALF_W = DATA_W / 2;

  logic              is_sub;
  logic              cin;
  logic [DATA_W-1:0] addend;
  logic [DATA_W:0]   wide_sum;
  logic [HALF_W:0]   narrow_sum;
  logic              sd, sa, sr;

  always_comb begin
    is_sub = (op_i == OP_SUB) || (op_i == OP_SUBC) || (op_i == OP_CMP);
    unique case (op_i)
      OP_ADDC, OP_SUBC: cin = carry_i;
      OP_SUB, OP_CMP:   cin = 1'b1;
      default:          cin = 1'b0;
    endcase
    addend     = is_sub ? ~src_i : src_i;
    wide_sum   = {1'b0, dst_i} + {1'b0, addend} + {{DATA_W{1'b0}}, cin};
    narrow_sum = {1'b0, dst_i[HALF_W-1:0]} + {1'b0, addend[HALF_W-1:0]}
               + {{HALF_W{1'b0}}, cin};
    if (byte_i) begin
      sum_o  = {{(DATA_W-HALF_W){1'b0}}, narrow_sum[HALF_W-1:0]};
      cout_o = narrow_sum[HALF_W];
      sd     = dst_i[HALF_W-1];
      sa     = addend[HALF_W-1];
      sr     = narrow_sum[HALF_W-1];
    end else begin
      sum_o  = wide_sum[DATA_W-1:0];
      cout_o = wide_sum[DATA_W];
      sd     = dst_i[DATA_W-1];
      sa     = addend[DATA_W-1];
      sr     = wide_sum[DATA_W-1];
    end
    ovf_o = (sd == sa) && (sr != sd);
  end

endmodule

// File: rtl/bw_alu_bcd.sv
module bw_alu_bcd #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic              byte_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o
);
  localparam int DIGITS   = DATA_W / 4;
  localparam int B_DIGITS = DIGITS / 2;

  function automatic int pow10(input int n);
    int p;
    p = 1;
    for (int k = 0; k < n; k++) p = p * 10;
    return p;
  endfunction

  int bin_sum;
  int used;

  always_comb begin
    used    = byte_i ? B_DIGITS : DIGITS;
    bin_sum = int'(carry_i);
    for (int i = 0; i < DIGITS; i++) begin
      if (i < used)
        bin_sum = bin_sum + (int'(dst_i[4*i +: 4]) + int'(src_i[4*i +: 4])) * pow10(i);
    end
    cout_o = bin_sum > (pow10(used) - 1);
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    always_comb begin
      if (g < used) sum_o[4*g +: 4] = 4'((bin_sum / pow10(g)) % 10);
      else          sum_o[4*g +: 4] = 4'd0;
    end
  end

endmodule

// File: rtl/bw_alu_shift.sv
module bw_alu_shift
  import bw_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] dst_i,
  input  alu_op_e           op_i,
  input  logic              byte_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] opnd;
  int                top;

  always_comb begin
    opnd   = byte_i ? {{(DATA_W-HALF_W){1'b0}}, dst_i[HALF_W-1:0]} : dst_i;
    top    = byte_i ? HALF_W - 1 : DATA_W - 1;
    cout_o = opnd[0];
    res_o  = opnd >> 1;
    unique case (op_i)
      OP_RRC:  res_o[top] = carry_i;
      OP_RRA:  res_o[top] = opnd[top];
      OP_SWPB: res_o = {dst_i[HALF_W-1:0], dst_i[DATA_W-1:HALF_W]};
      OP_SXT:  res_o = {{(DATA_W-HALF_W){dst_i[HALF_W-1]}}, dst_i[HALF_W-1:0]};
      default: ;
    endcase
  end

endmodule

// File: rtl/bw_alu.sv
module bw_alu
  import bw_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [3:0]        op_i,
  input  logic              byte_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FL_W-1:0]   flags_o,
  output logic [FL_W-1:0]   flag_we_o,
  output logic              result_we_o
);
  localparam int HALF_W = DATA_W / 2;

  alu_op_e           op;
  logic [DATA_W-1:0] dm, sm;
  logic [DATA_W-1:0] arith_r, bcd_r, shift_r;
  logic              arith_c, arith_v, bcd_c, shift_c;
  logic              full_word, eff_byte, z, n, sign_both;

  assign op        = alu_op_e'(op_i);
  assign full_word = (op == OP_SWPB) || (op == OP_SXT);
  assign eff_byte  = byte_i && !full_word;
  assign dm        = byte_i ? {{(DATA_W-HALF_W){1'b0}}, dst_i[HALF_W-1:0]} : dst_i;
  assign sm        = byte_i ? {{(DATA_W-HALF_W){1'b0}}, src_i[HALF_W-1:0]} : src_i;

  bw_alu_arith #(.DATA_W(DATA_W)) i_arith (
    .dst_i(dm), .src_i(sm), .op_i(op), .byte_i(byte_i), .carry_i(carry_i),
    .sum_o(arith_r), .cout_o(arith_c), .ovf_o(arith_v)
  );

  bw_alu_bcd #(.DATA_W(DATA_W)) i_bcd (
    .dst_i(dm), .src_i(sm), .byte_i(byte_i), .carry_i(carry_i),
    .sum_o(bcd_r), .cout_o(bcd_c)
  );

  bw_alu_shift #(.DATA_W(DATA_W)) i_shift (
    .dst_i(dst_i), .op_i(op), .byte_i(byte_i), .carry_i(carry_i),
    .res_o(shift_r), .cout_o(shift_c)
  );

  // result select
  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: result_o = arith_r;
      OP_DADD:                                  result_o = bcd_r;
      OP_AND, OP_BIT:                           result_o = dm & sm;
      OP_BIC:                                   result_o = dm & ~sm;
      OP_BIS:                                   result_o = dm | sm;
      OP_XOR:                                   result_o = dm ^ sm;
      default:                                  result_o = shift_r;
    endcase
    result_we_o = (op != OP_CMP) && (op != OP_BIT);
  end

  // status generation
  always_comb begin
    if (eff_byte) begin
      n         = result_o[HALF_W-1];
      z         = (result_o[HALF_W-1:0] == '0);
      sign_both = dm[HALF_W-1] & sm[HALF_W-1];
    end else begin
      n         = result_o[DATA_W-1];
      z         = (result_o == '0);
      sign_both = dm[DATA_W-1] & sm[DATA_W-1];
    end
    flags_o        = '0;
    flags_o[FL_N]  = n;
    flags_o[FL_Z]  = z;
    flag_we_o      = '1;
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        flags_o[FL_C] = arith_c;
        flags_o[FL_V] = arith_v;
      end
      OP_DADD: begin
        flags_o[FL_C]   = bcd_c;
        flag_we_o[FL_V] = 1'b0;
      end
      OP_AND, OP_BIT, OP_SXT: flags_o[FL_C] = !z;
      OP_XOR: begin
        flags_o[FL_C] = !z;
        flags_o[FL_V] = sign_both;
      end
      OP_RRC, OP_RRA, OP_RRL: flags_o[FL_C] = shift_c;
      default: begin
        flags_o   = '0;
        flag_we_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/bw_alu_chk.sv
module bw_alu_chk
  import bw_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic [3:0]        op_i,
  input logic              byte_i,
  input logic [DATA_W-1:0] result_o,
  input logic [FL_W-1:0]   flags_o,
  input logic [FL_W-1:0]   flag_we_o,
  input logic              result_we_o
);
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    // R7
    flag_hold_chk: assert (!(op_i == OP_BIC || op_i == OP_BIS || op_i == OP_SWPB)
                           || flag_we_o == '0);
    // R3
    no_writeback_chk: assert (!(op_i == OP_CMP || op_i == OP_BIT) || !result_we_o);
    // R11
    byte_upper_zero_chk: assert (!(byte_i && op_i != OP_SWPB && op_i != OP_SXT)
                                 || result_o[DATA_W-1:HALF_W] == '0);
    // R12
    zero_flag_chk: assert (!(flag_we_o[FL_Z] && !byte_i)
                           || flags_o[FL_Z] == (result_o == '0));
    // R5
    and_carry_chk: assert (!(op_i == OP_AND || op_i == OP_BIT)
                           || (flags_o[FL_C] == !flags_o[FL_Z] && !flags_o[FL_V]));
  end

endmodule

bind bw_alu bw_alu_chk #(.DATA_W(DATA_W)) i_chk (
  .op_i(op_i), .byte_i(byte_i), .result_o(result_o), .flags_o(flags_o),
  .flag_we_o(flag_we_o), .result_we_o(result_we_o)
);

// File: tb/test_bw_alu.sv
module test_bw_alu;
  import bw_alu_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 28;
  localparam int WATCHDOG   = 5000;

  typedef struct packed {
    logic [7:0]  req;
    logic [3:0]  op;
    logic        bm;
    logic        ci;
    logic [15:0] dst;
    logic [15:0] src;
    logic [15:0] res;
    logic [3:0]  fl;
    logic [3:0]  we;
    logic        wr;
  } vec_t;

  // flags order {V,N,Z,C}
  localparam vec_t VEC [NVEC] = '{
    '{8'd1,  4'd0,  1'b0, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 4'hC, 4'hF, 1'b1}, // R1 signed overflow
    '{8'd1,  4'd0,  1'b0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 4'h3, 4'hF, 1'b1}, // R1 carry out
    '{8'd11, 4'd0,  1'b1, 1'b0, 16'h12FF, 16'h3401, 16'h0000, 4'h3, 4'hF, 1'b1}, // R11 byte add
    '{8'd1,  4'd1,  1'b0, 1'b1, 16'h0001, 16'h0002, 16'h0004, 4'h0, 4'hF, 1'b1}, // R1 addc
    '{8'd2,  4'd2,  1'b0, 1'b0, 16'h0005, 16'h0003, 16'h0002, 4'h1, 4'hF, 1'b1}, // R2 no borrow
    '{8'd2,  4'd2,  1'b0, 1'b0, 16'h0003, 16'h0005, 16'hFFFE, 4'h4, 4'hF, 1'b1}, // R2 borrow
    '{8'd2,  4'd3,  1'b0, 1'b0, 16'h0005, 16'h0003, 16'h0001, 4'h1, 4'hF, 1'b1}, // R2 subc
    '{8'd2,  4'd2,  1'b1, 1'b0, 16'h0080, 16'h0001, 16'h007F, 4'h9, 4'hF, 1'b1}, // R2 byte overflow
    '{8'd3,  4'd4,  1'b0, 1'b0, 16'h1234, 16'h1234, 16'h0000, 4'h3, 4'hF, 1'b0}, // R3 compare
    '{8'd4,  4'd5,  1'b0, 1'b0, 16'h0199, 16'h0001, 16'h0200, 4'h0, 4'h7, 1'b1}, // R4 digit carry
    '{8'd4,  4'd5,  1'b0, 1'b0, 16'h9999, 16'h0001, 16'h0000, 4'h3, 4'h7, 1'b1}, // R4 word wrap
    '{8'd4,  4'd5,  1'b1, 1'b1, 16'hAA45, 16'hBB54, 16'h0000, 4'h3, 4'h7, 1'b1}, // R4 byte wrap
    '{8'd5,  4'd6,  1'b0, 1'b0, 16'hF0F0, 16'h8F00, 16'h8000, 4'h5, 4'hF, 1'b1}, // R5 and
    '{8'd5,  4'd6,  1'b0, 1'b0, 16'h00FF, 16'hFF00, 16'h0000, 4'h2, 4'hF, 1'b1}, // R5 and zero
    '{8'd5,  4'd7,  1'b1, 1'b0, 16'h0081, 16'h0080, 16'h0080, 4'h5, 4'hF, 1'b0}, // R5 bit test
    '{8'd7,  4'd8,  1'b0, 1'b1, 16'hFFFF, 16'h00F0, 16'hFF0F, 4'h0, 4'h0, 1'b1}, // R7 bic
    '{8'd7,  4'd9,  1'b0, 1'b0, 16'h1200, 16'h0034, 16'h1234, 4'h0, 4'h0, 1'b1}, // R7 bis
    '{8'd6,  4'd10, 1'b0, 1'b0, 16'h8001, 16'h8000, 16'h0001, 4'h9, 4'hF, 1'b1}, // R6 xor
    '{8'd6,  4'd10, 1'b1, 1'b0, 16'h00AA, 16'h00AA, 16'h0000, 4'hA, 4'hF, 1'b1}, // R6 byte xor
    '{8'd8,  4'd11, 1'b0, 1'b1, 16'h0001, 16'h0000, 16'h8000, 4'h5, 4'hF, 1'b1}, // R8 rrc word
    '{8'd8,  4'd11, 1'b1, 1'b0, 16'h0102, 16'h0000, 16'h0001, 4'h0, 4'hF, 1'b1}, // R8 rrc byte
    '{8'd9,  4'd12, 1'b0, 1'b0, 16'h8003, 16'h0000, 16'hC001, 4'h5, 4'hF, 1'b1}, // R9 rra word
    '{8'd9,  4'd12, 1'b1, 1'b0, 16'h0081, 16'h0000, 16'h00C0, 4'h5, 4'hF, 1'b1}, // R9 rra byte
    '{8'd9,  4'd13, 1'b0, 1'b1, 16'h8000, 16'h0000, 16'h4000, 4'h0, 4'hF, 1'b1}, // R9 rrl
    '{8'd10, 4'd14, 1'b1, 1'b0, 16'h12AB, 16'h0000, 16'hAB12, 4'h0, 4'h0, 1'b1}, // R10 swap
    '{8'd10, 4'd15, 1'b0, 1'b0, 16'h0080, 16'h0000, 16'hFF80, 4'h5, 4'hF, 1'b1}, // R10 sxt
    '{8'd10, 4'd15, 1'b1, 1'b0, 16'h1234, 16'h0000, 16'h0034, 4'h1, 4'hF, 1'b1}, // R10 sxt size ignored
    '{8'd12, 4'd2,  1'b0, 1'b0, 16'h8000, 16'h0001, 16'h7FFF, 4'h9, 4'hF, 1'b1}  // R12 sub overflow
  };

  logic        clk;
  logic [15:0] src, dst, res;
  logic [3:0]  op, fl, we;
  logic        bm, ci, wr;
  int          checks, errors;

  bw_alu i_bw_alu (
    .src_i(src), .dst_i(dst), .op_i(op), .byte_i(bm), .carry_i(ci),
    .result_o(res), .flags_o(fl), .flag_we_o(we), .result_we_o(wr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic apply(input vec_t v);
    @(posedge clk);
    op = v.op; bm = v.bm; ci = v.ci; dst = v.dst; src = v.src;
    @(negedge clk);
    checks++;
    if (res !== v.res || wr !== v.wr || we !== v.we || (fl & v.we) !== (v.fl & v.we)) begin
      errors++;
      $display("FAIL R%0d op=%0d: res=%h fl=%h we=%h wr=%b expected res=%h fl=%h we=%h wr=%b",
               v.req, v.op, res, fl & v.we, we, wr, v.res, v.fl & v.we, v.we, v.wr);
    end
  endtask

  initial begin
    checks = 0; errors = 0;
    op = '0; bm = 1'b0; ci = 1'b0; dst = '0; src = '0;
    // idle inputs: add of zeros, R12 zero flag
    apply('{8'd12, 4'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 4'h2, 4'hF, 1'b1});
    for (int i = 0; i < NVEC; i++) apply(VEC[i]);
    // R7 flags held even with carry in and byte size
    apply('{8'd7, 4'd9, 1'b1, 1'b1, 16'hFF80, 16'h8000, 16'h0080, 4'h0, 4'h0, 1'b1});
    // R11 upper operand bits ignored in byte xor
    apply('{8'd11, 4'd10, 1'b1, 1'b0, 16'hFF0F, 16'h55F0, 16'h00FF, 4'h5, 4'hF, 1'b1});
    // R4 byte decimal without carry out
    apply('{8'd4, 4'd5, 1'b1, 1'b0, 16'h0038, 16'h0045, 16'h0083, 4'h4, 4'h7, 1'b1});
    // R3 compare with borrow, no writeback
    apply('{8'd3, 4'd4, 1'b0, 1'b0, 16'h0001, 16'h0002, 16'hFFFF, 4'h4, 4'hF, 1'b0});
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected finish before %0d cycles", WATCHDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule